// File: doc/BRIEF.md
# Receive Ring Buffer with Watermark Flow Control

This block sits between a serial byte receiver and the code or logic that consumes received bytes. Incoming bytes are written into a 256-entry circular store at a write index. The consumer takes them from a read index through a valid/ready handshake. A separate occupancy counter tracks how many bytes are held and drives the empty and full outputs. One slot is always left unused, so that a full ring can be told apart from an empty one.

The block also throttles the remote sender. When occupancy climbs to a programmable upper watermark, it raises a request that asks the transmit path to insert the pause character (decimal 19). When occupancy later falls to a programmable lower watermark, it asks for the continue character (decimal 17). The request is held until the transmit side acknowledges it. If the opposite watermark is reached before that acknowledge, the pending character is swapped for the new one.

Top module: `rx_ring_flowctl`

## Requirements
- R1: After reset, is_empty is 1, fill_count is 0, pop_valid is 0, is_full is 0, overflow is 0 and fc_req is 0.
- R2: Bytes leave through pop_data in the order they were accepted. pop_valid is 1 exactly while at least one byte is held, and pop_data then shows the oldest byte.
- R3: A push is accepted when push_valid is 1 and is_full is 0, and it raises fill_count by one at the next clock edge. A pop happens when pop_ready is 1 and the buffer is not empty, and it lowers fill_count by one. When a push and a pop are both accepted in one cycle, fill_count is unchanged. is_empty is 1 exactly when fill_count is 0.
- R4: is_full is 1 exactly when 255 bytes are held (one below the 256-slot depth).
- R5: A push while is_full is 1 is dropped: fill_count is not raised and the stored bytes are not changed. From the next cycle on, overflow is 1, and it stays 1 until reset.
- R6: pop_ready while the buffer is empty has no effect. fill_count stays 0, and the next byte pushed is the next byte popped.
- R7: Suppose the block is not paused and fill_count becomes greater than or equal to high_mark. Then, in the same cycle that the new fill_count is visible, the block enters the paused state, fc_req is 1 and fc_char is 19.
- R8: Suppose the block is paused and fill_count becomes less than or equal to low_mark. Then, in the same cycle that the new fill_count is visible, the block leaves the paused state, fc_req is 1 and fc_char is 17.
- R9: fc_req stays 1 until a cycle in which fc_ack is 1, and it is 0 in the cycle after that. No further request is raised while occupancy stays on the same side of the watermark that was last crossed.
- R10: If the opposite watermark is reached while a request is still unacknowledged, fc_char takes the new character and fc_req stays 1.
- R11: The read and write indexes wrap modulo 256. Order and count remain correct after more than 256 bytes have passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Receiver offers a byte this cycle |
| push_data | input | 8 | Byte from the receiver |
| pop_valid | output | 1 | A byte is available to the consumer |
| pop_ready | input | 1 | Consumer takes the byte this cycle |
| pop_data | output | 8 | Oldest held byte |
| fill_count | output | 8 | Number of bytes held |
| is_empty | output | 1 | No bytes held |
| is_full | output | 1 | 255 bytes held; further pushes are dropped |
| overflow | output | 1 | Sticky: a push was dropped |
| high_mark | input | 8 | Occupancy at which the pause character is requested |
| low_mark | input | 8 | Occupancy at which the continue character is requested |
| fc_req | output | 1 | Flow-control character waiting for the transmit path |
| fc_char | output | 8 | Character to insert (19 pause, 17 continue) |
| fc_ack | input | 1 | Transmit path has taken the pending character |

## Verification
The stimulus starts with directed runs around the watermarks. These separate a first crossing, holding a level above the crossing, an acknowledge, and a reversal before the acknowledge; that last case is the one that exposes character replacement. A fill past capacity is followed by a drain past empty, which checks dropped pushes, the sticky overflow flag and ignored pops at both ends of the ring. After that come long sweeps with push-heavy, pop-heavy, balanced and bursty traffic under several watermark pairs. These move thousands of bytes through the ring, so wraparound, simultaneous push and pop, and repeated watermark crossings are all compared against an arithmetic queue model.

// File: rtl/rxfc_pkg.sv
`timescale 1ns/1ps
package rxfc_pkg;
    localparam logic [7:0] PAUSE_CHAR  = 8'd19;
    localparam logic [7:0] RESUME_CHAR = 8'd17;
endpackage

// File: rtl/rxfc_ptr_ctrl.sv
`timescale 1ns/1ps
module rxfc_ptr_ctrl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic          pop_ready,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] rd_idx,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] count_q,
    output logic [AW-1:0] count_d,
    output logic          empty,
    output logic          full,
    output logic          ovf
);
    typedef struct packed {
        logic [AW-1:0] head;
        logic [AW-1:0] tail;
        logic [AW-1:0] count;
        logic          ovf;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic empty_w, full_w, push_ok_w, pop_ok_w;

    always_comb begin
        st_d      = st_q;
        empty_w   = (st_q.head == st_q.tail);
        full_w    = ((st_q.tail + AW'(1)) == st_q.head);
        push_ok_w = push_valid && !full_w;
        pop_ok_w  = pop_ready && !empty_w;
        if (push_ok_w) st_d.tail = st_q.tail + AW'(1);
        if (pop_ok_w)  st_d.head = st_q.head + AW'(1);
        if (push_valid && full_w) st_d.ovf = 1'b1;
        unique case ({push_ok_w, pop_ok_w})
            2'b10:   st_d.count = st_q.count + AW'(1);
            2'b01:   st_d.count = st_q.count - AW'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push_ok = push_ok_w;
    assign pop_ok  = pop_ok_w;
    assign rd_idx  = st_q.head;
    assign wr_idx  = st_q.tail;
    assign count_q = st_q.count;
    assign count_d = st_d.count;
    assign empty   = empty_w;
    assign full    = full_w;
    assign ovf     = st_q.ovf;
endmodule

// File: rtl/rxfc_store.sv
`timescale 1ns/1ps
module rxfc_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxfc_flow.sv
`timescale 1ns/1ps
module rxfc_flow #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] level,
    input  logic [AW-1:0] high_mark,
    input  logic [AW-1:0] low_mark,
    input  logic          fc_ack,
    output logic          fc_req,
    output logic [7:0]    fc_char
);
    import rxfc_pkg::*;

    typedef struct packed {
        logic       stopped;
        logic       req;
        logic [7:0] chr;
    } flow_st_t;

    flow_st_t st_d, st_q;
    logic hit_high, hit_low;

    always_comb begin
        st_d     = st_q;
        hit_high = !st_q.stopped && (level >= high_mark);
        hit_low  = st_q.stopped && (level <= low_mark);
        if (st_q.req && fc_ack) st_d.req = 1'b0;
        if (hit_high) begin
            st_d.stopped = 1'b1;
            st_d.req     = 1'b1;
            st_d.chr     = PAUSE_CHAR;
        end else if (hit_low) begin
            st_d.stopped = 1'b0;
            st_d.req     = 1'b1;
            st_d.chr     = RESUME_CHAR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fc_req  = st_q.req;
    assign fc_char = st_q.chr;
endmodule

// File: rtl/rx_ring_flowctl.sv
`timescale 1ns/1ps
module rx_ring_flowctl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [DATA_W-1:0] pop_data,
    output logic [ADDR_W-1:0] fill_count,
    output logic              is_empty,
    output logic              is_full,
    output logic              overflow,
    input  logic [ADDR_W-1:0] high_mark,
    input  logic [ADDR_W-1:0] low_mark,
    output logic              fc_req,
    output logic [7:0]        fc_char,
    input  logic              fc_ack
);
    logic              push_ok, pop_ok;
    logic [ADDR_W-1:0] rd_idx, wr_idx, count_d;

    rxfc_ptr_ctrl #(.AW(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .pop_ready  (pop_ready),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .rd_idx     (rd_idx),
        .wr_idx     (wr_idx),
        .count_q    (fill_count),
        .count_d    (count_d),
        .empty      (is_empty),
        .full       (is_full),
        .ovf        (overflow)
    );

    rxfc_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_idx),
        .wdata (push_data),
        .raddr (rd_idx),
        .rdata (pop_data)
    );

    rxfc_flow #(.AW(ADDR_W)) u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (count_d),
        .high_mark (high_mark),
        .low_mark  (low_mark),
        .fc_ack    (fc_ack),
        .fc_req    (fc_req),
        .fc_char   (fc_char)
    );

    assign pop_valid = !is_empty;
endmodule

// File: rtl/rx_ring_flowctl_chk.sv
`timescale 1ns/1ps
module rx_ring_flowctl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          pop_valid,
    input logic          pop_ready,
    input logic [AW-1:0] fill_count,
    input logic          is_empty,
    input logic          is_full,
    input logic          overflow,
    input logic          fc_req,
    input logic [7:0]    fc_char,
    input logic          fc_ack
);
    // R4
    empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_empty && is_full));

    // R3
    empty_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty == (fill_count == '0));

    // R3
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !is_full && !(pop_valid && pop_ready))
        |=> fill_count == AW'($past(fill_count) + 1'b1));

    // R3
    both_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !is_full && pop_valid && pop_ready) |=> $stable(fill_count));

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && is_full) |=> overflow);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && !push_valid) |=> is_empty);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_req && !fc_ack) |=> fc_req);

    // R7
    char_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fc_req |-> (fc_char == 8'd19 || fc_char == 8'd17));
endmodule

bind rx_ring_flowctl rx_ring_flowctl_chk #(.AW(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready),
    .fill_count (fill_count),
    .is_empty   (is_empty),
    .is_full    (is_full),
    .overflow   (overflow),
    .fc_req     (fc_req),
    .fc_char    (fc_char),
    .fc_ack     (fc_ack)
);

// File: tb/rx_ring_flowctl_test.sv
`timescale 1ns/1ps
module rx_ring_flowctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_valid;
    logic       pop_ready = 1'b0;
    logic [7:0] pop_data;
    logic [7:0] fill_count;
    logic       is_empty, is_full, overflow;
    logic [7:0] high_mark = 8'd8;
    logic [7:0] low_mark = 8'd3;
    logic       fc_req;
    logic [7:0] fc_char;
    logic       fc_ack = 1'b0;

    int vectors = 0;
    int errors = 0;
    int seq = 0;
    int passed = 0;
    logic [7:0] mq[$];
    bit m_stopped = 0, m_req = 0, m_ovf = 0;
    logic [7:0] m_chr = 8'd0;
    string pop_tag = "R2";
    string flow_tag = "R7";
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    rx_ring_flowctl uut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
        .fill_count(fill_count), .is_empty(is_empty), .is_full(is_full),
        .overflow(overflow), .high_mark(high_mark), .low_mark(low_mark),
        .fc_req(fc_req), .fc_char(fc_char), .fc_ack(fc_ack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit pv, input bit pr, input bit ak);
        logic [7:0] pd;
        bit push_ok, pop_ok;
        int cnt;
        @(negedge clk);
        pd = 8'((seq * 37) + 11);
        push_valid = pv; push_data = pd; pop_ready = pr; fc_ack = ak;
        #1;
        chk("R2 pop_valid", int'(pop_valid), int'(mq.size() != 0));
        if (mq.size() != 0) chk(pop_tag, int'(pop_data), int'(mq[0]));
        push_ok = pv && (mq.size() < 255);
        pop_ok  = pr && (mq.size() > 0);
        if (pv && !push_ok) m_ovf = 1;
        if (pop_ok) void'(mq.pop_front());
        if (push_ok) begin mq.push_back(pd); seq++; end
        cnt = mq.size();
        if (m_req && ak) m_req = 0;
        if (!m_stopped && cnt >= int'(high_mark)) begin
            m_stopped = 1; m_req = 1; m_chr = 8'd19;
        end else if (m_stopped && cnt <= int'(low_mark)) begin
            m_stopped = 0; m_req = 1; m_chr = 8'd17;
        end
        @(posedge clk); #1;
        chk("R3 count", int'(fill_count), cnt);
        chk("R3 empty", int'(is_empty), int'(cnt == 0));
        chk("R4 full", int'(is_full), int'(cnt == 255));
        chk("R5 overflow", int'(overflow), int'(m_ovf));
        chk(flow_tag, int'(fc_req), int'(m_req));
        if (m_req) chk(flow_tag, int'(fc_char), int'(m_chr));
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 empty", int'(is_empty), 1);
        chk("R1 count", int'(fill_count), 0);
        chk("R1 pop_valid", int'(pop_valid), 0);
        chk("R1 full", int'(is_full), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 fc_req", int'(fc_req), 0);

        // R7: climb to high mark without acknowledge
        flow_tag = "R7";
        for (int i = 0; i < 8; i++) step(1, 0, 0);
        chk("R7 pause char", int'(fc_char), 19);
        // R9: request held, then cleared by acknowledge, no repeat above mark
        flow_tag = "R9";
        for (int i = 0; i < 5; i++) step(0, 0, 0);
        chk("R9 held", int'(fc_req), 1);
        step(0, 0, 1);
        chk("R9 cleared", int'(fc_req), 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0);
        chk("R9 no repeat", int'(fc_req), 0);
        // R8: drain to low mark
        flow_tag = "R8";
        for (int i = 0; i < 9; i++) step(0, 1, 0);
        chk("R8 resume char", int'(fc_char), 17);
        step(0, 0, 1);
        // R10: reverse before acknowledge
        flow_tag = "R10";
        for (int i = 0; i < 5; i++) step(1, 0, 0);
        chk("R10 pending pause", int'(fc_char), 19);
        for (int i = 0; i < 5; i++) step(0, 1, 0);
        chk("R10 replaced", int'(fc_char), 17);
        chk("R10 still req", int'(fc_req), 1);
        step(0, 0, 1);

        // R4/R5: fill past capacity, then push+pop while full
        flow_tag = "R7";
        high_mark = 8'd250; low_mark = 8'd5;
        for (int i = 0; i < 262; i++) step(1, 0, 1);
        chk("R4 full at 255", int'(is_full), 1);
        chk("R5 sticky ovf", int'(overflow), 1);
        step(1, 1, 1);
        chk("R5 push dropped while full", int'(fill_count), 254);
        // R6: drain past empty
        flow_tag = "R8";
        for (int i = 0; i < 260; i++) step(0, 1, 1);
        chk("R6 count stays 0", int'(fill_count), 0);
        step(1, 1, 1);
        step(0, 1, 1);
        chk("R6 empty after", int'(is_empty), 1);

        // R11: long sweeps across traffic patterns and mark pairs
        pop_tag = "R11 order";
        flow_tag = "R11 flow";
        for (int p = 0; p < 4; p++) begin
            case (p)
                0: begin high_mark = 8'd200; low_mark = 8'd120; end
                1: begin high_mark = 8'd20;  low_mark = 8'd4;   end
                2: begin high_mark = 8'd100; low_mark = 8'd50;  end
                default: begin high_mark = 8'd254; low_mark = 8'd1; end
            endcase
            for (int c = 0; c < 1500; c++) begin
                bit pv, pr;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (p)
                    0: begin pv = lfsr[1:0] != 2'b00; pr = lfsr[3:2] == 2'b00; end
                    1: begin pv = lfsr[1:0] == 2'b00; pr = lfsr[3:2] != 2'b00; end
                    2: begin pv = lfsr[0]; pr = lfsr[2]; end
                    default: begin pv = (c % 600) < 300; pr = (c % 600) >= 280; end
                endcase
                step(pv, pr, lfsr[5]);
            end
        end
        chk("R11 bytes through ring", int'(seq > 512), 1);

        @(negedge clk);
        push_valid = 0; pop_ready = 0; fc_ack = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule